// File: doc/BRIEF.md
# Receive Character Buffer with Error Tags

This block sits between a serial receiver and the host bus of a communication controller. Each character the receiver assembles arrives with three status bits: bit 0 is parity error, bit 1 is framing error and bit 2 is break. The block stores the character and its status bits together in a 64-entry first-in first-out buffer. The host reads the entries back in arrival order, and the status bits come out with the byte they belong to.

The block reports how full the buffer is. It also raises a ready output once the fill reaches a trigger threshold, and an interrupt controller or a DMA engine can use that output to service the buffer in bursts. The threshold is one of four fixed levels or a level programmed by software. A summary flag shows when any stored entry carries an error tag. A sticky flag records characters that were lost because the buffer was full. A flush input empties the buffer in one cycle.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `level`=0, `rxReady`=0, `anyErr`=0 and `overrun`=0.
- R2: Entries leave in the order they were written. While `empty`=0, `rdData` and `rdTag` show the oldest stored entry. `level`, `empty` and `full` reflect a write or a read from the cycle after its clock edge.
- R3: The buffer holds 64 entries, and `full`=1 exactly when `level`=64. A write while `full`=1 is dropped and leaves the contents unchanged, even when a read happens in the same cycle.
- R4: A write attempted while `full`=1 (and `flush`=0) sets `overrun` on the next cycle. `overrun` stays set until a cycle with `statusRd`=1. If a set and a clear occur in the same cycle, the set wins.
- R5: A read while `empty`=1 is ignored, and `level` stays 0.
- R6: The trigger threshold comes from `trigSel`: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 56. Values 4 to 7 select `progLevel`, with 0 treated as 1. `rxReady`=1 exactly when `level` is at or above the threshold.
- R7: `anyErr`=1 exactly when at least one stored entry has a nonzero tag. Tag bit 0 is parity error, bit 1 is framing error and bit 2 is break.
- R8: `flush`=1 empties the buffer in one cycle and clears `anyErr`. A write or read in the same cycle is ignored and does not set `overrun`. `flush` does not clear `overrun`.
- R9: A read and a write in the same cycle, while neither empty nor full, leave `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe from the receiver |
| wrData | input | 8 | Received character |
| wrTag | input | 3 | Error tag: bit0 parity, bit1 framing, bit2 break |
| rdEn | input | 1 | Read (pop) strobe from the host |
| flush | input | 1 | Empty the buffer |
| statusRd | input | 1 | Status read; clears the overrun flag |
| trigSel | input | 3 | Trigger threshold select |
| progLevel | input | 6 | Programmed threshold used when trigSel is 4 to 7 |
| rdData | output | 8 | Oldest stored character |
| rdTag | output | 3 | Tag of the oldest stored character |
| empty | output | 1 | No entries stored |
| full | output | 1 | 64 entries stored |
| level | output | 7 | Number of stored entries |
| rxReady | output | 1 | Fill is at or above the threshold |
| anyErr | output | 1 | Some stored entry has a nonzero tag |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The assertions take for granted that a push never reaches the storage while the buffer is full and a pop never reaches it while the buffer is empty. They check that the control enforces both rules, whatever strobes arrive at the ports. The stimulus drives `wrEn`, `rdEn`, `statusRd` and `flush` freely, including writes on a full buffer and reads on an empty one, so the guarding logic is exercised rather than bypassed. The random phases shift the write and read rates so the fill swings from empty to full, with occasional flushes and threshold changes, and directed sequences cover the same-cycle set and clear of `overrun`.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rxfStrobe_t;
endpackage

// File: rtl/rxf_trig_dec.sv
`timescale 1ns/1ps
module rxf_trig_dec #(
  parameter int CNT_W = 7,
  parameter int PRG_W = 6,
  parameter int LVL_A = 1,
  parameter int LVL_B = 16,
  parameter int LVL_C = 32,
  parameter int LVL_D = 56
) (
  input  logic [2:0]       trigSel,
  input  logic [PRG_W-1:0] progLevel,
  output logic [CNT_W-1:0] threshold
);
  always_comb begin
    case (trigSel)
      3'd0:    threshold = CNT_W'(LVL_A);
      3'd1:    threshold = CNT_W'(LVL_B);
      3'd2:    threshold = CNT_W'(LVL_C);
      3'd3:    threshold = CNT_W'(LVL_D);
      default: threshold = (progLevel == '0) ? CNT_W'(1) : CNT_W'(progLevel);
    endcase
  end
endmodule

// File: rtl/rxf_ctrl.sv
`timescale 1ns/1ps
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             flush,
  input  logic             statusRd,
  input  logic [CNT_W-1:0] threshold,
  output rxfStrobe_t       strobe,
  output logic [CNT_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             rxReady,
  output logic             overrun
);
  logic [CNT_W-1:0] levelQ;
  logic             ovrQ;
  logic             dropWr;

  assign empty   = (levelQ == '0);
  assign full    = (levelQ == CNT_W'(DEPTH));
  assign level   = levelQ;
  assign overrun = ovrQ;
  assign rxReady = (levelQ >= threshold);

  assign strobe.clear = flush;
  assign strobe.push  = wrEn && !full && !flush;
  assign strobe.pop   = rdEn && !empty && !flush;
  assign dropWr       = wrEn && full && !flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      ovrQ   <= 1'b0;
    end else begin
      if (strobe.clear) levelQ <= '0;
      else levelQ <= levelQ + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
      if (dropWr) ovrQ <= 1'b1;
      else if (statusRd) ovrQ <= 1'b0;
    end
  end

  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobe.push);
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= CNT_W'(DEPTH));
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !strobe.pop);
  a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !flush) |=> overrun);
  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !statusRd) |=> overrun);
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);
  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && !empty && !full && !flush) |=> $stable(level));
endmodule

// File: rtl/rxf_datapath.sv
`timescale 1ns/1ps
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxfStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TAG_W-1:0]  wrTag,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdTag,
  output logic              anyErr
);
  localparam int ENT_W = DATA_W + TAG_W;

  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] errCnt;
  logic [ENT_W-1:0] headEntry;
  logic             pushErr, popErr;

  assign headEntry = store[rdPtr];
  assign rdData    = headEntry[DATA_W-1:0];
  assign rdTag     = headEntry[ENT_W-1:DATA_W];
  assign pushErr   = strobe.push && (wrTag != '0);
  assign popErr    = strobe.pop && (rdTag != '0);
  assign anyErr    = (errCnt != '0);

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= {wrTag, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      errCnt <= '0;
    end else if (strobe.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      errCnt <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      errCnt <= errCnt + CNT_W'(pushErr) - CNT_W'(popErr);
    end
  end

  a_r8_flush_clears_err: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !anyErr);
  a_r7_err_push_flags: assert property (@(posedge clk) disable iff (!rstN)
    (pushErr && !strobe.clear) |=> anyErr);
  a_r7_err_bound: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/rx_err_fifo.sv
`timescale 1ns/1ps
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3,
  parameter int PRG_W  = 6,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic              rdEn,
  input  logic              flush,
  input  logic              statusRd,
  input  logic [2:0]        trigSel,
  input  logic [PRG_W-1:0]  progLevel,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0]  rdTag,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  level,
  output logic              rxReady,
  output logic              anyErr,
  output logic              overrun
);
  rxfStrobe_t       strobe;
  logic [CNT_W-1:0] threshold;

  rxf_trig_dec #(.CNT_W(CNT_W), .PRG_W(PRG_W)) uTrig (
    .trigSel(trigSel), .progLevel(progLevel), .threshold(threshold)
  );

  rxf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .flush(flush),
    .statusRd(statusRd), .threshold(threshold), .strobe(strobe),
    .level(level), .empty(empty), .full(full), .rxReady(rxReady),
    .overrun(overrun)
  );

  rxf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .wrTag(wrTag),
    .rdData(rdData), .rdTag(rdTag), .anyErr(anyErr)
  );

  a_r2_empty_full_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));
  a_r7_err_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |-> !empty);
endmodule

// File: tb/tb_rx_err_fifo.sv
`timescale 1ns/1ps
module tb_rx_err_fifo;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 0, rdEn = 0, flush = 0, statusRd = 0;
  logic [7:0] wrData = 0;
  logic [2:0] wrTag = 0, trigSel = 0;
  logic [5:0] progLevel = 0;
  logic [7:0] rdData;
  logic [2:0] rdTag;
  logic       empty, full, rxReady, anyErr, overrun;
  logic [6:0] level;

  int  nChecks = 0, nFails = 0;
  bit  done = 0;
  logic [10:0] model[$];
  bit  ovrM = 0;
  logic [2:0] curSel = 0;
  logic [5:0] curProg = 0;

  always #10 clk = ~clk;

  rx_err_fifo dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrTag(wrTag),
    .rdEn(rdEn), .flush(flush), .statusRd(statusRd), .trigSel(trigSel),
    .progLevel(progLevel), .rdData(rdData), .rdTag(rdTag), .empty(empty),
    .full(full), .level(level), .rxReady(rxReady), .anyErr(anyErr),
    .overrun(overrun)
  );

  function automatic int thrOf(logic [2:0] s, logic [5:0] p);
    case (s)
      3'd0: return 1;
      3'd1: return 16;
      3'd2: return 32;
      3'd3: return 56;
      default: return (p == 0) ? 1 : int'(p);
    endcase
  endfunction

  function automatic bit errPresent();
    foreach (model[i]) if (model[i][10:8] != 3'b0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    int n = model.size();
    chk("R2/R3 level", int'(level), n);
    chk("R2 empty", int'(empty), int'(n == 0));
    chk("R3 full", int'(full), int'(n == 64));
    chk("R6 rxReady", int'(rxReady), int'(n >= thrOf(curSel, curProg)));
    chk("R7 anyErr", int'(anyErr), int'(errPresent()));
    chk("R4 overrun", int'(overrun), int'(ovrM));
    if (n != 0) begin
      chk("R2 rdData", int'(rdData), int'(model[0][7:0]));
      chk("R2/R7 rdTag", int'(rdTag), int'(model[0][10:8]));
    end
  endtask

  // one cycle: check state, drive inputs at negedge, update model
  task automatic cyc(bit w, logic [7:0] d, logic [2:0] t, bit r, bit f, bit s,
                     logic [2:0] sel, logic [5:0] pg);
    bit wasFull = (model.size() == 64);
    bit wasEmpty = (model.size() == 0);
    checkAll();
    wrEn = w; wrData = d; wrTag = t; rdEn = r; flush = f; statusRd = s;
    trigSel = sel; progLevel = pg;
    curSel = sel; curProg = pg;
    if (w && wasFull && !f) ovrM = 1'b1;
    else if (s) ovrM = 1'b0;
    if (f) model.delete();
    else begin
      if (r && !wasEmpty) void'(model.pop_front());
      if (w && !wasFull) model.push_back({t, d});
    end
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; rdEn = 0; flush = 0; statusRd = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll();
    rstN = 1'b1;
    @(negedge clk);
    checkAll();
    // R5: read while empty
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 level after empty read", int'(level), 0);
    // R2/R6/R7: fill to full with tags, threshold 56
    for (int i = 0; i < 64; i++)
      cyc(1, 8'(i * 7 + 3), (i == 10) ? 3'b100 : 3'b000, 0, 0, 0, 3'd3, 0);
    // R3/R4: write on full with read same cycle is dropped
    cyc(1, 8'hAA, 3'b001, 1, 0, 0, 3'd3, 0);
    chk("R3 dropped write level", int'(level), 63);
    chk("R4 overrun after drop", int'(overrun), 1);
    // R4: set wins over clear
    cyc(1, 8'h55, 0, 0, 0, 0, 3'd3, 0);
    cyc(1, 8'h66, 0, 0, 0, 1, 3'd3, 0);
    chk("R4 set beats clear", int'(overrun), 1);
    cyc(0, 0, 0, 0, 0, 1, 3'd3, 0);
    chk("R4 cleared by statusRd", int'(overrun), 0);
    // R6: programmed levels, including 0 treated as 1
    cyc(0, 0, 0, 0, 0, 0, 3'd5, 6'd0);
    cyc(0, 0, 0, 0, 0, 0, 3'd7, 6'd63);
    // R9: read+write hold level
    cyc(0, 0, 0, 1, 0, 0, 3'd2, 0);
    cyc(1, 8'h11, 3'b010, 1, 0, 0, 3'd2, 0);
    chk("R9 level held", int'(level), 63);
    // R8: flush with concurrent write on a full buffer
    cyc(1, 8'h22, 0, 0, 0, 0, 3'd2, 0);
    cyc(1, 8'h33, 3'b001, 1, 1, 0, 3'd2, 0);
    chk("R8 flush empties", int'(level), 0);
    chk("R8 flush clears anyErr", int'(anyErr), 0);
    chk("R8 flush keeps overrun low", int'(overrun), 0);
    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      int wp = (ph == 0) ? 80 : (ph == 1) ? 50 : (ph == 2) ? 25 : 95;
      int rp = (ph == 0) ? 30 : (ph == 1) ? 50 : (ph == 2) ? 75 : 10;
      logic [2:0] sel = curSel;
      logic [5:0] pg = curProg;
      for (int k = 0; k < 800; k++) begin
        bit w = ($urandom % 100) < wp;
        bit r = ($urandom % 100) < rp;
        bit f = ($urandom % 128) == 0;
        bit s = ($urandom % 16) == 0;
        logic [2:0] t = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
        if (($urandom % 32) == 0) begin
          sel = 3'($urandom);
          pg = 6'($urandom);
        end
        cyc(w, 8'($urandom), t, r, f, s, sel, pg);
      end
    end
    // drain and final check
    while (model.size() != 0) cyc(0, 0, 0, 1, 0, 0, 3'd0, 0);
    checkAll();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule